// File: doc/BRIEF.md
# Programmable Loopback Code Transmitter

This block inserts a repeating, unframed in-band loopback code into a serial transmit bit stream. It advances one bit for each line-clock enable strobe. A static configuration supplies a code pattern, a length select and a two-bit maintenance-pattern mode with a companion pattern-clock control bit. While the code is being sent, the code bits replace the normal transmit data. At all other times the normal data passes through unchanged. The block does not know whether the code means activate or deactivate; the receiver at the far end decides that.

The code is read most-significant bit first. A code of length L sends `code_pat[7]` down to `code_pat[8-L]` and then starts again at the first bit, with no gap. A 3-bit code is sent by programming it twice as a 6-bit code. A 4-bit code is sent by programming it twice as an 8-bit code. A change to the pattern or length written during transmission is latched only when a new repetition begins, so no repetition is ever partial. Both outputs are registered and change only on an enable strobe.

Top module: `lbc_tx_top`

## Requirements
- R1: While reset is asserted and after it is released, before any enable, `tx_data_out` is 0 and `code_active` is 0.
- R2: While the code is inactive and `pat_mode` is not 2'b11, each enable copies `tx_data_in` to `tx_data_out` and keeps `code_active` at 0.
- R3: An enable with `pat_mode` = 2'b11 while inactive starts the code: `code_active` becomes 1 and `tx_data_out` carries `code_pat[7]` on that same enable.
- R4: While active, enable number k after the start (k = 0, 1, 2, ...) outputs `code_pat[7 - (k mod L)]`. The code repeats continuously and ignores `tx_data_in`.
- R5: Length select encoding: `len_sel` 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8.
- R6: An enable with `pat_mode` = 2'b00 and `pat_clk_ctl` = 0 while active ends the code. On that same enable, `code_active` returns to 0 and `tx_data_out` carries `tx_data_in`.
- R7: While active, `pat_mode` 2'b01, 2'b10, or 2'b00 with `pat_clk_ctl` = 1 leaves the code running without a break. While inactive, these settings do not start it.
- R8: A change to `code_pat` or `len_sel` during a repetition takes effect only at the first bit of the next repetition. The current repetition finishes with the old pattern and length.
- R9: Without `bit_en`, both outputs hold their values whatever the other inputs do.
- R10: A 3-bit code programmed twice into a 6-bit length (pattern 101101xx, `len_sel` 2'b01) is sent as an unbroken 101 101 101 ... stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe per line bit |
| tx_data_in | input | 1 | Normal transmit data |
| code_pat | input | 8 | Code pattern, MSB sent first |
| len_sel | input | 2 | Code length select |
| pat_mode | input | 2 | Maintenance-pattern mode, 2'b11 sends the code |
| pat_clk_ctl | input | 1 | Pattern-clock control; must be 0 with mode 2'b00 to end the code |
| tx_data_out | output | 1 | Transmit data after insertion |
| code_active | output | 1 | High while the code replaces transmit data |

## Verification
The hardest case to reach is a pattern and length change that arrives in the middle of a repetition. To expose an early reload, the change must land several bits before a code boundary. The stimulus starts an 8-bit code, waits three enables, and then writes a new 5-bit pattern whose bits differ from the old pattern's tail. The bench checks that the old tail finishes and that the new code starts exactly at the boundary. Mode switches to the holding settings are also placed mid-code, so that a lost bit position shows up as a wrong bit.

// File: rtl/lbc_pkg.sv
`timescale 1ns/1ps
package lbc_pkg;

   typedef enum logic [1:0] {
      PM_IDLE = 2'b00,
      PM_AUX1 = 2'b01,
      PM_AUX2 = 2'b10,
      PM_CODE = 2'b11
   } pmode_e;

   // length in bits for a select value: MIN_LEN plus the select
   function automatic int unsigned code_len(input int unsigned sel, input int unsigned min_len);
      return min_len + sel;
   endfunction

endpackage

// File: rtl/lbc_ctrl.sv
`timescale 1ns/1ps
module lbc_ctrl
   import lbc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic [1:0] pat_mode,
   input  logic       pat_clk_ctl,
   output logic       start_now,
   output logic       emit_now
);

   logic   run_q;
   logic   stop_now;
   pmode_e mode;

   assign mode      = pmode_e'(pat_mode);
   assign start_now = bit_en && !run_q && (mode == PM_CODE);
   assign stop_now  = bit_en && run_q && (mode == PM_IDLE) && !pat_clk_ctl;
   assign emit_now  = start_now || (bit_en && run_q && !stop_now);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
      end else if (bit_en) begin
         run_q <= emit_now;
      end
   end

endmodule

// File: rtl/lbc_seq.sv
`timescale 1ns/1ps
module lbc_seq #(
   parameter int unsigned PAT_W   = 8,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned MIN_LEN = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_now,
   input  logic             emit_now,
   input  logic [PAT_W-1:0] code_pat,
   input  logic [SEL_W-1:0] len_sel,
   output logic             code_bit
);

   localparam int unsigned IDX_W = $clog2(PAT_W + 1);

   logic [PAT_W-1:0] shadow_pat;
   logic [IDX_W-1:0] shadow_len;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] live_len;
   logic             boundary;
   logic [PAT_W-1:0] pick;
   logic             old_bit;

   assign live_len = IDX_W'(MIN_LEN) + IDX_W'(len_sel);
   assign boundary = start_now || (idx_q >= shadow_len);

   // one-hot AND-OR pick of the stored bit at the current position
   for (genvar p = 0; p < PAT_W; p++) begin : g_pick
      assign pick[p] = shadow_pat[PAT_W-1-p] && (idx_q == IDX_W'(p));
   end
   assign old_bit  = |pick;
   assign code_bit = boundary ? code_pat[PAT_W-1] : old_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_pat <= '0;
         shadow_len <= IDX_W'(MIN_LEN);
         idx_q      <= '0;
      end else if (emit_now) begin
         if (boundary) begin
            shadow_pat <= code_pat;
            shadow_len <= live_len;
            idx_q      <= IDX_W'(1);
         end else begin
            idx_q      <= idx_q + IDX_W'(1);
         end
      end
   end

endmodule

// File: rtl/lbc_outreg.sv
`timescale 1ns/1ps
module lbc_outreg (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic emit_now,
   input  logic code_bit,
   input  logic tx_data_in,
   output logic tx_data_out,
   output logic code_active
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_data_out <= 1'b0;
         code_active <= 1'b0;
      end else if (bit_en) begin
         tx_data_out <= emit_now ? code_bit : tx_data_in;
         code_active <= emit_now;
      end
   end

endmodule

// File: rtl/lbc_tx_top.sv
`timescale 1ns/1ps
module lbc_tx_top #(
   parameter int unsigned PAT_W   = 8,
   parameter int unsigned SEL_W   = 2,
   parameter int unsigned MIN_LEN = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             tx_data_in,
   input  logic [PAT_W-1:0] code_pat,
   input  logic [SEL_W-1:0] len_sel,
   input  logic [1:0]       pat_mode,
   input  logic             pat_clk_ctl,
   output logic             tx_data_out,
   output logic             code_active
);

   localparam int unsigned MAX_LEN = MIN_LEN + (1 << SEL_W) - 1;

   if (MAX_LEN > PAT_W) begin : g_bad_len
      $error("lbc_tx_top: longest code exceeds pattern width");
   end
   if (MIN_LEN < 1) begin : g_bad_min
      $error("lbc_tx_top: MIN_LEN must be at least 1");
   end

   logic start_now;
   logic emit_now;
   logic code_bit;

   lbc_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .pat_mode    (pat_mode),
      .pat_clk_ctl (pat_clk_ctl),
      .start_now   (start_now),
      .emit_now    (emit_now)
   );

   lbc_seq #(
      .PAT_W   (PAT_W),
      .SEL_W   (SEL_W),
      .MIN_LEN (MIN_LEN)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_now (start_now),
      .emit_now  (emit_now),
      .code_pat  (code_pat),
      .len_sel   (len_sel),
      .code_bit  (code_bit)
   );

   lbc_outreg u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .emit_now    (emit_now),
      .code_bit    (code_bit),
      .tx_data_in  (tx_data_in),
      .tx_data_out (tx_data_out),
      .code_active (code_active)
   );

endmodule

// File: rtl/lbc_tx_chk.sv
`timescale 1ns/1ps
module lbc_tx_chk #(
   parameter int unsigned PAT_W = 8,
   parameter int unsigned SEL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bit_en,
   input logic             tx_data_in,
   input logic [PAT_W-1:0] code_pat,
   input logic [SEL_W-1:0] len_sel,
   input logic [1:0]       pat_mode,
   input logic             pat_clk_ctl,
   input logic             tx_data_out,
   input logic             code_active
);

   p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && !code_active && pat_mode != 2'b11
      |=> !code_active && tx_data_out == $past(tx_data_in));

   p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && !code_active && pat_mode == 2'b11
      |=> code_active && tx_data_out == $past(code_pat[PAT_W-1]));

   p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && code_active && pat_mode == 2'b00 && !pat_clk_ctl
      |=> !code_active && tx_data_out == $past(tx_data_in));

   p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en && code_active && !(pat_mode == 2'b00 && !pat_clk_ctl)
      |=> code_active);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_data_out) && $stable(code_active));

endmodule

bind lbc_tx_top lbc_tx_chk #(.PAT_W(PAT_W), .SEL_W(SEL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bit_en      (bit_en),
   .tx_data_in  (tx_data_in),
   .code_pat    (code_pat),
   .len_sel     (len_sel),
   .pat_mode    (pat_mode),
   .pat_clk_ctl (pat_clk_ctl),
   .tx_data_out (tx_data_out),
   .code_active (code_active)
);

// File: tb/tb_lbc_tx_top.sv
`timescale 1ns/1ps
module tb_lbc_tx_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       tx_data_in = 1'b0;
   logic [7:0] code_pat = 8'h00;
   logic [1:0] len_sel = 2'b00;
   logic [1:0] pat_mode = 2'b00;
   logic       pat_clk_ctl = 1'b0;
   logic       tx_data_out;
   logic       code_active;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   lbc_tx_top dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_en      (bit_en),
      .tx_data_in  (tx_data_in),
      .code_pat    (code_pat),
      .len_sel     (len_sel),
      .pat_mode    (pat_mode),
      .pat_clk_ctl (pat_clk_ctl),
      .tx_data_out (tx_data_out),
      .code_active (code_active)
   );

   task automatic chk(input string req, input string what, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: %s got %b expected %b", req, what, got, exp);
      end
   endtask

   // one enable strobe; outputs sampled on the following falling edge
   task automatic step(input logic din);
      @(negedge clk);
      bit_en     = 1'b1;
      tx_data_in = din;
      @(negedge clk);
      bit_en     = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "tx_data_out", tx_data_out, 1'b0);
      chk("R1", "code_active", code_active, 1'b0);
   endtask

   task automatic t_pass();
      pat_mode = 2'b00; pat_clk_ctl = 1'b0;
      for (int k = 0; k < 12; k++) begin
         logic d;
         d = logic'((k * 7 + 3) % 5 > 1);
         step(d);
         chk("R2", "pass data", tx_data_out, d);
         chk("R2", "inactive", code_active, 1'b0);
      end
   endtask

   task automatic t_len(input logic [7:0] pat, input logic [1:0] sel, input string req);
      int len;
      len      = 5 + int'(sel);
      code_pat = pat;
      len_sel  = sel;
      pat_mode = 2'b11;
      for (int k = 0; k < 3 * len; k++) begin
         step(logic'(k % 2));
         chk(k == 0 ? "R3" : req, "code bit", tx_data_out, pat[7 - (k % len)]);
         chk(req, "active", code_active, 1'b1);
      end
      pat_mode = 2'b00; pat_clk_ctl = 1'b0;
      step(1'b1);
      chk("R6", "stop data", tx_data_out, 1'b1);
      chk("R6", "stop inactive", code_active, 1'b0);
      step(1'b0);
      chk("R6", "after stop", tx_data_out, 1'b0);
   endtask

   task automatic t_hold_modes();
      logic [7:0] pat;
      pat = 8'hB4;
      code_pat = pat; len_sel = 2'b10; pat_mode = 2'b11; pat_clk_ctl = 1'b0;
      for (int k = 0; k < 14; k++) begin
         if (k == 3) pat_mode = 2'b01;
         if (k == 6) pat_mode = 2'b10;
         if (k == 9) begin pat_mode = 2'b00; pat_clk_ctl = 1'b1; end
         step(1'b1);
         chk("R7", "code bit", tx_data_out, pat[7 - (k % 7)]);
         chk("R7", "active", code_active, 1'b1);
      end
      pat_clk_ctl = 1'b0;
      step(1'b0);
      chk("R6", "stop inactive", code_active, 1'b0);
      for (int m = 0; m < 3; m++) begin
         logic d;
         d = logic'(m % 2);
         pat_mode    = (m == 0) ? 2'b01 : (m == 1) ? 2'b10 : 2'b00;
         pat_clk_ctl = (m == 2);
         step(d);
         chk("R7", "no start data", tx_data_out, d);
         chk("R7", "no start", code_active, 1'b0);
      end
      pat_clk_ctl = 1'b0; pat_mode = 2'b00;
   endtask

   task automatic t_boundary();
      logic [7:0] a, b;
      a = 8'hC5; b = 8'h3A;
      code_pat = a; len_sel = 2'b11; pat_mode = 2'b11;
      for (int k = 0; k < 18; k++) begin
         logic e;
         if (k == 3) begin code_pat = b; len_sel = 2'b00; end
         e = (k < 8) ? a[7 - k] : b[7 - ((k - 8) % 5)];
         step(1'b0);
         chk("R8", "code bit", tx_data_out, e);
      end
      pat_mode = 2'b00;
      step(1'b0);
      chk("R6", "stop inactive", code_active, 1'b0);
   endtask

   task automatic t_no_enable();
      logic [7:0] pat;
      pat = 8'h96;
      code_pat = pat; len_sel = 2'b01; pat_mode = 2'b11;
      step(1'b0); step(1'b0);
      chk("R4", "bit 1", tx_data_out, pat[6]);
      pat_mode = 2'b00; pat_clk_ctl = 1'b0; code_pat = 8'h00;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         tx_data_in = ~tx_data_in;
         chk("R9", "hold data", tx_data_out, pat[6]);
         chk("R9", "hold active", code_active, 1'b1);
      end
      pat_mode = 2'b11; code_pat = pat;
      step(1'b0);
      chk("R9", "resume bit 2", tx_data_out, pat[5]);
      pat_mode = 2'b00;
      step(1'b1);
      chk("R6", "stop data", tx_data_out, 1'b1);
   endtask

   initial begin
      #800000;
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pass();
      t_len(8'hA7, 2'b00, "R5");
      t_len(8'h6C, 2'b01, "R5");
      t_len(8'hD3, 2'b10, "R4");
      t_len(8'h59, 2'b11, "R4");
      t_len(8'b1011_0100, 2'b01, "R10");
      t_hold_modes();
      t_boundary();
      t_no_enable();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule